// File: doc/BRIEF.md
# Upward-Growing Hardware Stack with Pointer Control

This block keeps an 8-bit stack pointer and runs the read and write cycles against a 256-byte RAM that it holds internally. A push request moves the pointer up by one and then stores the byte at the new location. A pop request reads the byte the pointer currently addresses and then moves the pointer down by one. The popped byte appears on a registered result port together with a one-cycle valid strobe.

After reset the pointer is 07h, so the first byte that is pushed goes to address 08h. Software can move the stack anywhere by loading the pointer, for example into the upper half of RAM. The pointer wraps modulo 256 and raises no flag when it does.

A wide mode moves a 16-bit value as two bytes over two cycles. A wide push writes the low byte first and then the high byte. A wide pop takes the bytes back in reverse order and returns the word already put together. This suits return-address-sized items.

Top module: `stk_ptr_unit`

## Requirements
- R1: Reset has these effects:
  - the pointer goes to 07h;
  - `busy_o` goes low;
  - `rd_valid_o` goes low.
- R2: A narrow push accepted while idle has these effects:
  - the pointer becomes pointer+1, visible right after the accepting edge;
  - `push_data_i[7:0]` is stored at that new address;
  - the first push after reset lands at 08h.
- R3: A narrow pop accepted while idle has these effects:
  - the byte at the current pointer is read;
  - the pointer becomes pointer-1;
  - right after the accepting edge, `rd_valid_o` is 1 for one cycle;
  - `rd_data_o` then holds the byte in bits [7:0], with bits [15:8] at zero.
- R4: When push and pop are requested in the same idle cycle, the push is carried out. The pop is dropped: no `rd_valid_o`, and the pointer only increments.
- R5: A pointer load (`sp_load_i`) takes effect only in an idle cycle with no push and no pop request. The pointer then equals `sp_load_val_i` after the edge. In every other cycle the load is ignored.
- R6: The pointer wraps without any flag:
  - a push at FFh moves the pointer to 00h and writes at 00h;
  - a pop at 00h reads 00h and moves the pointer to FFh.
- R7: A wide push (`push_i` with `wide_i`) stores two bytes:
  - `push_data_i[7:0]` at pointer+1;
  - `push_data_i[15:8]` at pointer+2, on the next edge;
  - `busy_o` is 1 during the cycle between the two edges;
  - the pointer ends at pointer+2.
- R8: A wide pop reads in two steps:
  - first the high byte at the pointer, then the low byte at pointer-1;
  - after the second edge, `rd_valid_o` is 1 and `rd_data_o` is {high, low};
  - the pointer ends at pointer-2.
- R9: While `busy_o` is 1, every push, pop and load request is ignored. `busy_o` never stays high for more than one cycle.
- R10: Bytes come off the stack in the reverse of the order in which they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| wide_i | input | 1 | Selects a two-byte transfer for the push or pop |
| push_data_i | input | 16 | Push data; bits [7:0] only in narrow mode |
| sp_load_i | input | 1 | Request to load the pointer |
| sp_load_val_i | input | 8 | Value loaded into the pointer |
| sp_o | output | 8 | Current stack pointer |
| busy_o | output | 1 | Second step of a wide transfer is in progress |
| rd_valid_o | output | 1 | One-cycle strobe marking popped data |
| rd_data_o | output | 16 | Popped data; high byte zero for narrow pops |

## Verification
The results arrive at different times:
- A narrow push, a narrow pop or a pointer load is complete one edge after acceptance. The new pointer, the valid strobe and the byte must all be present right after that edge.
- A wide operation needs two edges. After the first, `busy_o` is high and the pointer has moved by one. After the second, the pointer has moved by two and, for a pop, the assembled word is valid.

The bench changes inputs on the falling edge and samples on the next falling edge, so each stimulus row states its result exactly one rising edge later. The idle row that follows a wide operation carries the expectations due at the second edge.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_HI = 2'd1,
    ST_POP_LO  = 2'd2
  } stk_state_e;

endpackage

// File: rtl/stk_ram.sv
// Single-port RAM. The read output is registered and changes only on a read,
// so block RAM can be inferred.
module stk_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/stk_ctrl.sv
// Pointer register and sequencer. Priority in an idle cycle:
// push first, then pop, then load.
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int          AW     = 8,
  parameter int          DW     = 8,
  parameter logic [AW-1:0] RST_SP = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            wide_i,
  input  logic [2*DW-1:0] push_data_i,
  input  logic            sp_load_i,
  input  logic [AW-1:0]   sp_load_val_i,
  output logic [AW-1:0]   sp_o,
  output logic            busy_o,
  output logic            ram_we_o,
  output logic            ram_re_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdata_o,
  output logic            rd_last_o,
  output logic            rd_wide_o,
  output logic            cap_hi_o
);
  stk_state_e    state_q, state_d;
  logic [AW-1:0] sp_q, sp_d, sp_inc, sp_dec;
  logic [DW-1:0] hold_q, hold_d;

  assign sp_inc = sp_q + 1'b1;
  assign sp_dec = sp_q - 1'b1;

  always_comb begin
    state_d     = state_q;
    sp_d        = sp_q;
    hold_d      = hold_q;
    ram_we_o    = 1'b0;
    ram_re_o    = 1'b0;
    ram_addr_o  = sp_q;
    ram_wdata_o = push_data_i[DW-1:0];
    rd_last_o   = 1'b0;
    rd_wide_o   = 1'b0;
    cap_hi_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (push_i) begin
          ram_we_o   = 1'b1;
          ram_addr_o = sp_inc;
          sp_d       = sp_inc;
          if (wide_i) begin
            hold_d  = push_data_i[2*DW-1:DW];
            state_d = ST_PUSH_HI;
          end
        end else if (pop_i) begin
          ram_re_o   = 1'b1;
          ram_addr_o = sp_q;
          sp_d       = sp_dec;
          if (wide_i) state_d = ST_POP_LO;
          else        rd_last_o = 1'b1;
        end else if (sp_load_i) begin
          sp_d = sp_load_val_i;
        end
      end
      ST_PUSH_HI: begin
        ram_we_o    = 1'b1;
        ram_addr_o  = sp_inc;
        ram_wdata_o = hold_q;
        sp_d        = sp_inc;
        state_d     = ST_IDLE;
      end
      ST_POP_LO: begin
        ram_re_o   = 1'b1;
        ram_addr_o = sp_q;
        sp_d       = sp_dec;
        rd_last_o  = 1'b1;
        rd_wide_o  = 1'b1;
        cap_hi_o   = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sp_q    <= RST_SP;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      hold_q  <= hold_d;
    end
  end

  assign sp_o   = sp_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/stk_rdout.sv
// Result stage: builds the popped word from the RAM read register.
module stk_rdout #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   ram_q_i,
  input  logic            rd_last_i,
  input  logic            rd_wide_i,
  input  logic            cap_hi_i,
  output logic            valid_o,
  output logic [2*DW-1:0] data_o
);
  logic          valid_q, wide_q;
  logic [DW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      wide_q  <= 1'b0;
      hi_q    <= '0;
    end else begin
      valid_q <= rd_last_i;
      if (rd_last_i) wide_q <= rd_wide_i;
      if (cap_hi_i)  hi_q   <= ram_q_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = {(wide_q ? hi_q : {DW{1'b0}}), ram_q_i};
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
  parameter int            AW     = 8,
  parameter int            DW     = 8,
  parameter logic [AW-1:0] RST_SP = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            wide_i,
  input  logic [2*DW-1:0] push_data_i,
  input  logic            sp_load_i,
  input  logic [AW-1:0]   sp_load_val_i,
  output logic [AW-1:0]   sp_o,
  output logic            busy_o,
  output logic            rd_valid_o,
  output logic [2*DW-1:0] rd_data_o
);
  logic          ram_we, ram_re, rd_last, rd_wide, cap_hi;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_q;

  stk_ctrl #(.AW(AW), .DW(DW), .RST_SP(RST_SP)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .wide_i       (wide_i),
    .push_data_i  (push_data_i),
    .sp_load_i    (sp_load_i),
    .sp_load_val_i(sp_load_val_i),
    .sp_o         (sp_o),
    .busy_o       (busy_o),
    .ram_we_o     (ram_we),
    .ram_re_o     (ram_re),
    .ram_addr_o   (ram_addr),
    .ram_wdata_o  (ram_wdata),
    .rd_last_o    (rd_last),
    .rd_wide_o    (rd_wide),
    .cap_hi_o     (cap_hi)
  );

  stk_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_q)
  );

  stk_rdout #(.DW(DW)) u_rdout (
    .clk      (clk),
    .rst      (rst),
    .ram_q_i  (ram_q),
    .rd_last_i(rd_last),
    .rd_wide_i(rd_wide),
    .cap_hi_i (cap_hi),
    .valid_o  (rd_valid_o),
    .data_o   (rd_data_o)
  );
endmodule

// File: rtl/stk_ptr_unit_chk.sv
module stk_ptr_unit_chk #(
  parameter int            AW     = 8,
  parameter logic [AW-1:0] RST_SP = 8'h07
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          pop_i,
  input logic          wide_i,
  input logic          sp_load_i,
  input logic [AW-1:0] sp_load_val_i,
  input logic [AW-1:0] sp_o,
  input logic          busy_o,
  input logic          rd_valid_o
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sp_o == RST_SP && !busy_o && !rd_valid_o));

  assert_push_incr_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && push_i) |=> (sp_o == AW'($past(sp_o) + 1'b1)));

  assert_pop_decr_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && pop_i && !push_i && !wide_i) |=>
      (rd_valid_o && sp_o == AW'($past(sp_o) - 1'b1)));

  assert_push_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && push_i && pop_i) |=> !rd_valid_o);

  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && sp_load_i && !push_i && !pop_i) |=> (sp_o == $past(sp_load_val_i)));

  assert_wide_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && push_i && wide_i) |=> busy_o);

  assert_busy_short_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !busy_o);

  assert_valid_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(pop_i) && !$past(busy_o)) |-> !rd_valid_o);
endmodule

bind stk_ptr_unit stk_ptr_unit_chk #(.AW(AW), .RST_SP(RST_SP)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .wide_i       (wide_i),
  .sp_load_i    (sp_load_i),
  .sp_load_val_i(sp_load_val_i),
  .sp_o         (sp_o),
  .busy_o       (busy_o),
  .rd_valid_o   (rd_valid_o)
);

// File: tb/stk_ptr_unit_bench.sv
module stk_ptr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 1'b0, pop_i = 1'b0, wide_i = 1'b0, sp_load_i = 1'b0;
  logic [15:0] push_data_i = '0;
  logic [7:0]  sp_load_val_i = '0;
  logic [7:0]  sp_o;
  logic        busy_o, rd_valid_o;
  logic [15:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  stk_ptr_unit u_stk_ptr_unit (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .wide_i(wide_i),
    .push_data_i(push_data_i), .sp_load_i(sp_load_i), .sp_load_val_i(sp_load_val_i),
    .sp_o(sp_o), .busy_o(busy_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  typedef struct packed {
    logic        push;
    logic        pop;
    logic        wide;
    logic        load;
    logic [15:0] data;
    logic [7:0]  esp;
    logic        ev;
    logic [15:0] edata;
    logic        ebusy;
  } vec_t;

  localparam int NV = 24;
  // Fields: push, pop, wide, load, data (load value = data[7:0]),
  // then expected sp, valid, data and busy one rising edge later.
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,16'h0011,8'h08,1'b0,16'h0000,1'b0}, // R2 first push at 08h
    '{1'b1,1'b0,1'b0,1'b0,16'h0022,8'h09,1'b0,16'h0000,1'b0}, // R2
    '{1'b0,1'b1,1'b0,1'b0,16'h0000,8'h08,1'b1,16'h0022,1'b0}, // R3 R10
    '{1'b1,1'b1,1'b0,1'b0,16'h0033,8'h09,1'b0,16'h0000,1'b0}, // R4
    '{1'b0,1'b1,1'b0,1'b0,16'h0000,8'h08,1'b1,16'h0033,1'b0}, // R4 push stored
    '{1'b0,1'b1,1'b0,1'b0,16'h0000,8'h07,1'b1,16'h0011,1'b0}, // R10
    '{1'b0,1'b0,1'b0,1'b1,16'h0080,8'h80,1'b0,16'h0000,1'b0}, // R5 relocate
    '{1'b1,1'b0,1'b1,1'b0,16'hBEEF,8'h81,1'b0,16'h0000,1'b1}, // R7 first edge
    '{1'b1,1'b1,1'b0,1'b1,16'h0055,8'h82,1'b0,16'h0000,1'b0}, // R9 all ignored
    '{1'b1,1'b0,1'b0,1'b0,16'h0066,8'h83,1'b0,16'h0000,1'b0}, // R2
    '{1'b0,1'b1,1'b0,1'b0,16'h0000,8'h82,1'b1,16'h0066,1'b0}, // R3
    '{1'b0,1'b1,1'b1,1'b0,16'h0000,8'h81,1'b0,16'h0000,1'b1}, // R8 first edge
    '{1'b1,1'b0,1'b0,1'b0,16'h0044,8'h80,1'b1,16'hBEEF,1'b0}, // R8 word, R9 push ignored
    '{1'b1,1'b0,1'b0,1'b1,16'h0077,8'h81,1'b0,16'h0000,1'b0}, // R5 load loses to push
    '{1'b0,1'b1,1'b0,1'b1,16'h0010,8'h80,1'b1,16'h0077,1'b0}, // R5 load loses to pop
    '{1'b0,1'b0,1'b0,1'b1,16'h00FF,8'hFF,1'b0,16'h0000,1'b0}, // R5
    '{1'b1,1'b0,1'b0,1'b0,16'h009A,8'h00,1'b0,16'h0000,1'b0}, // R6 wrap up
    '{1'b0,1'b1,1'b0,1'b0,16'h0000,8'hFF,1'b1,16'h009A,1'b0}, // R6
    '{1'b0,1'b0,1'b0,1'b1,16'h0000,8'h00,1'b0,16'h0000,1'b0}, // R5
    '{1'b0,1'b1,1'b0,1'b0,16'h0000,8'hFF,1'b1,16'h009A,1'b0}, // R6 wrap down
    '{1'b1,1'b0,1'b1,1'b0,16'hC3A5,8'h00,1'b0,16'h0000,1'b1}, // R7 across wrap
    '{1'b0,1'b0,1'b0,1'b0,16'h0000,8'h01,1'b0,16'h0000,1'b0}, // R7
    '{1'b0,1'b1,1'b1,1'b0,16'h0000,8'h00,1'b0,16'h0000,1'b1}, // R8
    '{1'b0,1'b0,1'b0,1'b0,16'h0000,8'hFF,1'b1,16'hC3A5,1'b0}  // R8 R10
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 9:         return "R2";
      2, 10:           return "R3";
      3, 4:            return "R4";
      5:               return "R10";
      6, 13, 14, 15, 18: return "R5";
      7, 20, 21:       return "R7";
      8:               return "R9";
      11, 12, 22, 23:  return "R8";
      default:         return "R6";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic p, logic q, logic w, logic l, logic [15:0] d);
    push_i = p; pop_i = q; wide_i = w; sp_load_i = l;
    push_data_i = d; sp_load_val_i = d[7:0];
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "sp", {8'h00, sp_o}, 16'h0007);
    chk("R1", "busy", {15'h0, busy_o}, 16'h0);
    chk("R1", "valid", {15'h0, rd_valid_o}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].push, VEC[i].pop, VEC[i].wide, VEC[i].load, VEC[i].data);
      @(negedge clk);
      chk(req_of(i), "sp", {8'h00, sp_o}, {8'h00, VEC[i].esp});
      chk(req_of(i), "valid", {15'h0, rd_valid_o}, {15'h0, VEC[i].ev});
      chk(req_of(i), "busy", {15'h0, busy_o}, {15'h0, VEC[i].ebusy});
      if (VEC[i].ev) chk(req_of(i), "data", rd_data_o, VEC[i].edata);
    end

    // R1: reset in the middle of a wide push
    drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h1234);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "sp after mid reset", {8'h00, sp_o}, 16'h0007);
    chk("R1", "busy after mid reset", {15'h0, busy_o}, 16'h0);
    chk("R1", "valid after mid reset", {15'h0, rd_valid_o}, 16'h0);

    // R2 R3: push then pop after reset
    drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h00AB);
    @(negedge clk);
    chk("R2", "sp after push", {8'h00, sp_o}, 16'h0008);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 16'h0000);
    @(negedge clk);
    chk("R3", "pop data", rd_data_o, 16'h00AB);
    chk("R3", "sp after pop", {8'h00, sp_o}, 16'h0007);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    @(negedge clk);
    chk("R3", "valid one cycle", {15'h0, rd_valid_o}, 16'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule